// File: doc/BRIEF.md
# Shared-Tick Timer Table

This block keeps a table of up to sixteen down-counting timers that all advance on one common tick. A prescaler turns the clock into that tick: while the global run input is high it emits a one-cycle tick every `tick_div + 1` clocks, and a free-running tick counter records how many ticks have gone by. A host sets the channels up one at a time. It places a channel number, an on/off flag, a mode flag and a period on the command inputs, then pulses the command strobe for one cycle. Because the run input can be raised after all channels are loaded, every channel starts in the same tick phase.

Each channel is a small state machine with three states. `CH_OFF` is idle. `CH_ONCE` is running in one-shot mode. `CH_AUTO` is running in auto-restart mode. The transitions are as follows:
- An enable command moves any state to `CH_ONCE` or `CH_AUTO` and loads the period.
- A disable command moves any state to `CH_OFF`.
- Expiry in `CH_ONCE` returns the channel to `CH_OFF`.
- Expiry in `CH_AUTO` stays in `CH_AUTO` and reloads the period.

The prescaler has two states. `TG_HALT` is entered whenever run is low. `TG_COUNT` is entered whenever run is high.

When a channel expires it sets its bit in a sticky event register. A write-one-to-clear port clears event bits. A mask register selects which events feed one registered interrupt output. The `NUM_CH` parameter sets how many channels exist. Command, event and mask traffic for channel numbers `NUM_CH` and above has no effect, and those bits always read zero.

Top module: `tick_timer_table`

## Requirements
- R1: While `run_en` is high the prescaler produces a tick once every `tick_div + 1` clock cycles. While `run_en` is low it produces no ticks and restarts its phase from zero.
- R2: `tick_cnt` rises by one for each tick. A cycle with `tick_cnt_clr` high sets it to zero, and the clear wins over a simultaneous tick.
- R3: A command with `cmd_on` = 1 loads `cmd_period` into channel `cmd_chan` and starts it. The channel expires on the tick at which its count reaches zero, so it expires after `cmd_period` ticks. A period of 0 behaves as a period of 1.
- R4: A channel started with `cmd_restart` = 1 reloads its period on the expiring tick and keeps expiring every period.
- R5: A channel started with `cmd_restart` = 0 expires once, then stops and raises no further events.
- R6: A command with `cmd_on` = 0 stops the channel, and its `cmd_restart` and `cmd_period` values have no effect.
- R7: Bit k of `evt_q` is channel k. It is set in the cycle after the expiring tick and stays set until cleared. When `evt_clr_we` is high, a 1 in `evt_clr_bits` clears the bit and a 0 leaves it unchanged. An expiry in the same cycle as a clear leaves the bit set.
- R8: Bit k of `mask_q` is channel k, and `mask_we` loads it from `mask_bits`. `irq` is high in the cycle after any bit of `evt_q & mask_q` is high.
- R9: Channels at index `NUM_CH` and above ignore commands, and their `evt_q` and `mask_q` bits always read 0.
- R10: After reset, `evt_q`, `mask_q`, `tick_cnt` and `irq` are zero, and all channels are in `CH_OFF`.
- R11: A command to a channel in the same cycle as a tick takes priority. The channel does not expire on that tick, and it takes the newly commanded state and period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Global tick enable |
| tick_div | input | DIV_W | Tick interval minus one, in clocks |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_chan | input | 4 | Channel addressed by the command |
| cmd_on | input | 1 | 1 starts the channel, 0 stops it |
| cmd_restart | input | 1 | 1 selects auto-restart, 0 selects one-shot |
| cmd_period | input | PER_W | Timeout in ticks |
| evt_clr_we | input | 1 | Event clear strobe |
| evt_clr_bits | input | 16 | Ones clear the matching event bits |
| mask_we | input | 1 | Mask write strobe |
| mask_bits | input | 16 | New mask value |
| tick_cnt_clr | input | 1 | Clears the tick counter |
| evt_q | output | 16 | Event register |
| mask_q | output | 16 | Mask register |
| tick_cnt | output | TCNT_W | Elapsed tick count |
| irq | output | 1 | Registered interrupt |

## Verification
The bench builds the block with `NUM_CH` = 6 and keeps the default widths. This leaves channels 6 to 15 present on the command, clear and mask ports, so it can show that they stay inert. The bench changes `tick_div` at run time between 0 and 3. A divide of 0 gives a tick on every clock, which makes it easy to hit an expiry in the same cycle as a clear, and a command on the same tick as an expiry. Larger divides exercise the prescaler phase and the restarts after a run stop.

// File: rtl/tt_pkg.sv
package tt_pkg;
    localparam int MAX_CH   = 16;
    localparam int CH_IDX_W = 4;

    typedef enum logic [1:0] {
        CH_OFF  = 2'd0,
        CH_ONCE = 2'd1,
        CH_AUTO = 2'd2
    } ch_state_e;

    typedef enum logic {
        TG_HALT  = 1'b0,
        TG_COUNT = 1'b1
    } tg_state_e;
endpackage

// File: rtl/tt_tick_gen.sv
module tt_tick_gen
    import tt_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic [DIV_W-1:0] tick_div,
    output logic             tick
);
    tg_state_e        st_q;
    logic [DIV_W-1:0] pcnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= TG_HALT;
        else        st_q <= run_en ? TG_COUNT : TG_HALT;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt_q <= '0;
            tick   <= 1'b0;
        end else begin
            unique case (st_q)
                TG_HALT: begin
                    pcnt_q <= '0;
                    tick   <= 1'b0;
                end
                TG_COUNT: begin
                    if (!run_en) begin
                        pcnt_q <= '0;
                        tick   <= 1'b0;
                    end else if (pcnt_q >= tick_div) begin
                        pcnt_q <= '0;
                        tick   <= 1'b1;
                    end else begin
                        pcnt_q <= pcnt_q + 1'b1;
                        tick   <= 1'b0;
                    end
                end
                default: begin
                    pcnt_q <= '0;
                    tick   <= 1'b0;
                end
            endcase
        end
    end

    AST_TICK_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> !tick); // R1
endmodule

// File: rtl/tt_slot.sv
module tt_slot
    import tt_pkg::*;
#(
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cmd_hit,
    input  logic             cmd_on,
    input  logic             cmd_restart,
    input  logic [PER_W-1:0] cmd_period,
    output logic             expire
);
    ch_state_e        st_q, st_d;
    logic [PER_W-1:0] cnt_q, per_q;
    logic             fire;

    always_comb begin
        fire = tick && (st_q != CH_OFF) && (cnt_q <= PER_W'(1)) && !cmd_hit;
        st_d = st_q;
        unique case (st_q)
            CH_OFF:  begin end
            CH_ONCE: if (fire) st_d = CH_OFF;
            CH_AUTO: begin end
            default: st_d = CH_OFF;
        endcase
        if (cmd_hit) begin
            if (!cmd_on)          st_d = CH_OFF;
            else if (cmd_restart) st_d = CH_AUTO;
            else                  st_d = CH_ONCE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= CH_OFF;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            per_q <= '0;
        end else if (cmd_hit && cmd_on) begin
            cnt_q <= cmd_period;
            per_q <= cmd_period;
        end else if (tick && (st_q != CH_OFF)) begin
            if (fire) cnt_q <= (st_q == CH_AUTO) ? per_q : '0;
            else      cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire = fire;

    AST_ONCE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CH_ONCE && fire) |=> (st_q == CH_OFF)); // R5
    AST_AUTO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CH_AUTO && fire) |=> (st_q == CH_AUTO && cnt_q == $past(per_q))); // R4
    AST_DISABLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_hit && !cmd_on) |=> (st_q == CH_OFF)); // R6
endmodule

// File: rtl/tick_timer_table.sv
module tick_timer_table
    import tt_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int PER_W  = 16,
    parameter int DIV_W  = 16,
    parameter int TCNT_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run_en,
    input  logic [DIV_W-1:0]    tick_div,
    input  logic                cmd_valid,
    input  logic [CH_IDX_W-1:0] cmd_chan,
    input  logic                cmd_on,
    input  logic                cmd_restart,
    input  logic [PER_W-1:0]    cmd_period,
    input  logic                evt_clr_we,
    input  logic [MAX_CH-1:0]   evt_clr_bits,
    input  logic                mask_we,
    input  logic [MAX_CH-1:0]   mask_bits,
    input  logic                tick_cnt_clr,
    output logic [MAX_CH-1:0]   evt_q,
    output logic [MAX_CH-1:0]   mask_q,
    output logic [TCNT_W-1:0]   tick_cnt,
    output logic                irq
);
    localparam logic [MAX_CH-1:0] IMPL_MASK = MAX_CH'((32'd1 << NUM_CH) - 32'd1);

    logic              tick;
    logic [MAX_CH-1:0] expire_vec;
    logic [MAX_CH-1:0] clr_vec;

    tt_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_en   (run_en),
        .tick_div (tick_div),
        .tick     (tick)
    );

    for (genvar k = 0; k < MAX_CH; k++) begin : g_slot
        if (k < NUM_CH) begin : g_on
            tt_slot #(.PER_W(PER_W)) u_slot (
                .clk         (clk),
                .rst_n       (rst_n),
                .tick        (tick),
                .cmd_hit     (cmd_valid && (cmd_chan == CH_IDX_W'(k))),
                .cmd_on      (cmd_on),
                .cmd_restart (cmd_restart),
                .cmd_period  (cmd_period),
                .expire      (expire_vec[k])
            );
        end else begin : g_off
            assign expire_vec[k] = 1'b0;
        end
    end

    assign clr_vec = evt_clr_we ? evt_clr_bits : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_q    <= '0;
            mask_q   <= '0;
            tick_cnt <= '0;
            irq      <= 1'b0;
        end else begin
            evt_q <= ((evt_q & ~clr_vec) | expire_vec) & IMPL_MASK;
            if (mask_we) mask_q <= mask_bits & IMPL_MASK;
            if (tick_cnt_clr) tick_cnt <= '0;
            else if (tick)    tick_cnt <= tick_cnt + 1'b1;
            irq <= |(evt_q & mask_q);
        end
    end

    AST_TCNT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        tick_cnt_clr |=> (tick_cnt == '0)); // R2
    AST_TCNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_cnt_clr && !tick) |=> $stable(tick_cnt)); // R2
    AST_EVT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_clr_we |=> ((evt_q & $past(evt_q)) == $past(evt_q))); // R7
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_q & mask_q) == '0) |=> !irq); // R8
endmodule

// File: tb/sim_tick_timer_table.sv
`timescale 1ns/1ps
module sim_tick_timer_table;
    localparam int NCH = 6;
    localparam logic [15:0] IMPL = 16'h003F;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        run_en;
    logic [15:0] tick_div;
    logic        cmd_valid;
    logic [3:0]  cmd_chan;
    logic        cmd_on, cmd_restart;
    logic [15:0] cmd_period;
    logic        evt_clr_we;
    logic [15:0] evt_clr_bits;
    logic        mask_we;
    logic [15:0] mask_bits;
    logic        tick_cnt_clr;
    logic [15:0] evt_q, mask_q, tick_cnt;
    logic        irq;

    always #2 clk = ~clk;

    tick_timer_table #(.NUM_CH(NCH)) u0 (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .tick_div(tick_div),
        .cmd_valid(cmd_valid), .cmd_chan(cmd_chan), .cmd_on(cmd_on),
        .cmd_restart(cmd_restart), .cmd_period(cmd_period),
        .evt_clr_we(evt_clr_we), .evt_clr_bits(evt_clr_bits),
        .mask_we(mask_we), .mask_bits(mask_bits), .tick_cnt_clr(tick_cnt_clr),
        .evt_q(evt_q), .mask_q(mask_q), .tick_cnt(tick_cnt), .irq(irq)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference state: 0 off, 1 one-shot, 2 auto
    bit          m_tg, m_tick, m_irq;
    int          m_pc;
    logic [15:0] m_tc, m_evt, m_mask;
    int          m_st  [16];
    logic [15:0] m_cnt [16];
    logic [15:0] m_per [16];

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] expiries();
        logic [15:0] e = '0;
        for (int k = 0; k < NCH; k++)
            if (m_tick && m_st[k] != 0 && m_cnt[k] <= 16'd1 &&
                !(cmd_valid && cmd_chan == 4'(k))) e[k] = 1'b1;
        return e;
    endfunction

    task automatic model_step();
        logic [15:0] e = expiries();
        logic [15:0] clr = evt_clr_we ? evt_clr_bits : 16'h0;
        bit n_tick = 1'b0;
        int n_pc = 0;
        for (int k = 0; k < NCH; k++) begin
            if (cmd_valid && cmd_chan == 4'(k)) begin
                if (cmd_on) begin
                    m_st[k]  = cmd_restart ? 2 : 1;
                    m_cnt[k] = cmd_period;
                    m_per[k] = cmd_period;
                end else m_st[k] = 0;
            end else if (m_tick && m_st[k] != 0) begin
                if (e[k]) begin
                    m_cnt[k] = (m_st[k] == 2) ? m_per[k] : 16'h0;
                    if (m_st[k] == 1) m_st[k] = 0;
                end else m_cnt[k] = m_cnt[k] - 16'd1;
            end
        end
        m_irq = |(m_evt & m_mask);
        m_evt = ((m_evt & ~clr) | e) & IMPL;
        if (mask_we) m_mask = mask_bits & IMPL;
        if (tick_cnt_clr) m_tc = 16'h0;
        else if (m_tick)  m_tc = m_tc + 16'd1;
        if (m_tg && run_en) begin
            if (m_pc >= int'(tick_div)) begin n_pc = 0; n_tick = 1'b1; end
            else n_pc = m_pc + 1;
        end
        m_tg = run_en;
        m_pc = n_pc;
        m_tick = n_tick;
    endtask

    task automatic quiet();
        cmd_valid = 0; cmd_chan = 0; cmd_on = 0; cmd_restart = 0; cmd_period = 0;
        evt_clr_we = 0; evt_clr_bits = 0; mask_we = 0; mask_bits = 0; tick_cnt_clr = 0;
    endtask

    // one clock: inputs already driven at negedge; compare at the next negedge
    task automatic cyc();
        model_step();
        @(posedge clk);
        @(negedge clk);
        chk(tick_cnt == m_tc, "R1,R2 tick_cnt", 32'(tick_cnt), 32'(m_tc));
        chk(evt_q == m_evt, "R3,R4,R5,R6,R7,R9,R11 evt_q", 32'(evt_q), 32'(m_evt));
        chk(mask_q == m_mask, "R8,R9 mask_q", 32'(mask_q), 32'(m_mask));
        chk(irq == m_irq, "R8 irq", 32'(irq), 32'(m_irq));
        quiet();
    endtask

    task automatic send(int ch, bit on, bit rs, int per);
        cmd_valid = 1; cmd_chan = 4'(ch); cmd_on = on; cmd_restart = rs;
        cmd_period = 16'(per);
        cyc();
    endtask

    task automatic clear_evt(logic [15:0] b);
        evt_clr_we = 1; evt_clr_bits = b;
        cyc();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd4242));
        quiet();
        rst_n = 0; run_en = 0; tick_div = 16'd0;
        m_tg = 0; m_tick = 0; m_irq = 0; m_pc = 0;
        m_tc = 0; m_evt = 0; m_mask = 0;
        for (int k = 0; k < 16; k++) begin m_st[k] = 0; m_cnt[k] = 0; m_per[k] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R10: reset state
        chk(evt_q == 0 && mask_q == 0 && tick_cnt == 0 && irq == 0, "R10 reset",
            {evt_q, mask_q}, 32'h0);

        // R9: mask bits above NUM_CH read zero
        mask_we = 1; mask_bits = 16'hFFFF; cyc();
        chk(mask_q == 16'h003F, "R9 mask width", 32'(mask_q), 32'h3F);

        // R1: no ticks while stopped
        repeat (8) cyc();
        chk(tick_cnt == 0, "R1 halted", 32'(tick_cnt), 32'h0);

        // R3/R5: one-shot ch2 period 3 at divide 0
        send(2, 1, 0, 3);
        run_en = 1; cyc();
        repeat (10) begin run_en = 1; cyc(); end
        chk(evt_q[2] == 1'b1, "R3 one-shot fired", 32'(evt_q), 32'h4);
        chk(irq == 1'b1, "R8 irq raised", 32'(irq), 32'h1);
        run_en = 1; clear_evt(16'h0004);
        repeat (12) begin run_en = 1; cyc(); end
        chk(evt_q[2] == 1'b0, "R5 one-shot stays quiet", 32'(evt_q), 32'h0);

        // R7: set wins over clear with an every-tick auto channel
        run_en = 1; send(1, 1, 1, 1);
        repeat (3) begin run_en = 1; cyc(); end
        for (int i = 0; i < 6; i++) begin
            run_en = 1; clear_evt(16'h0002);
            chk(evt_q[1] == 1'b1, "R7 set beats clear", 32'(evt_q), 32'h2);
        end
        // R6: disable with other fields set, they are ignored
        run_en = 1; send(1, 0, 1, 0);
        run_en = 1; clear_evt(16'h0002);
        repeat (10) begin run_en = 1; cyc(); end
        chk(evt_q[1] == 1'b0, "R6 disabled stays quiet", 32'(evt_q), 32'h0);

        // R9: commands to absent channels do nothing
        run_en = 1; send(10, 1, 1, 1);
        repeat (10) begin run_en = 1; cyc(); end
        chk((evt_q & ~IMPL) == 0, "R9 absent channel", 32'(evt_q), 32'(evt_q & IMPL));

        // R2: clear of the tick counter
        run_en = 1; tick_cnt_clr = 1; cyc();
        chk(tick_cnt == 0, "R2 counter clear", 32'(tick_cnt), 32'h0);

        // constrained random traffic, model compared every cycle (R1-R11)
        for (int i = 0; i < 6000; i++) begin
            if ($urandom_range(0, 199) == 0) run_en = ~run_en;
            if ($urandom_range(0, 299) == 0) tick_div = 16'($urandom_range(0, 3));
            if ($urandom_range(0, 7) == 0) begin
                cmd_valid = 1; cmd_chan = 4'($urandom_range(0, 15));
                cmd_on = ($urandom_range(0, 3) != 0); cmd_restart = 1'($urandom);
                cmd_period = 16'($urandom_range(0, 6));
            end
            if ($urandom_range(0, 5) == 0) begin
                evt_clr_we = 1; evt_clr_bits = 16'($urandom);
            end
            if ($urandom_range(0, 39) == 0) begin
                mask_we = 1; mask_bits = 16'($urandom);
            end
            if ($urandom_range(0, 59) == 0) tick_cnt_clr = 1;
            cyc();
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule